// File: doc/BRIEF.md
# Addressable Nine-Bit Serial Port

This block is a full-duplex asynchronous serial port driven through a small register file. Software sends a byte by writing the data register, which loads the transmit shifter and starts a frame at once. The same register address, when read, returns the most recently accepted received byte. Bit timing comes from an external strobe, `baud_tick`, which pulses at sixteen times the bit rate. Both the transmitter and the receiver count that strobe.

The receiver samples the line at bit centres. Each completed frame is copied into a holding register, so the next frame can shift in while software is still collecting the previous byte. The receiver flags a frame that ends with a low stop bit, and it also flags a byte that overwrites an unread one. In nine-bit multiprocessor mode, a frame is accepted only when its ninth bit is set and its low eight bits equal a programmable station address. The comparison covers only the bit positions that a mask register enables. Non-matching data frames therefore never disturb a listening station.

Two completion flags, one for transmit and one for receive, are ORed into a single interrupt line. Hardware never clears them. Software clears each one separately with a register write.

Top module: `mpsp_uart`

## Requirements
- R1: After reset, every register reads 0 (control, data, station address, mask, error), `txd` is 1 and `irq` is 0.
- R2: A frame on `txd` is a 0 start bit, then the eight data bits LSB first, then (only in nine-bit mode, control bit 6) the TB8 value from control bit 3, then a 1 stop bit. Each bit lasts OSR ticks of `baud_tick`.
- R3: The transmit-done flag (control bit 1) is set when the stop bit ends. A write to the data register while a frame is being sent is ignored.
- R4: A received byte with a high stop bit is stored in the holding register and can be read at register 1. Storing it sets the receive-done flag (control bit 0). In nine-bit mode the ninth received bit is copied into RB8 (control bit 2).
- R5: While receive-enable (control bit 4) is 0, line activity leaves receive-done and the holding register unchanged.
- R6: Reading register 1 empties the holding register. If a byte is stored while the holding register is still full, the overrun flag (control bit 7) is set and the newer byte replaces the older one. A byte stored after a read does not set the flag.
- R7: The overrun flag stays set until software writes the control register.
- R8: A frame whose stop bit is sampled low sets the framing-error flag (register 4, bit 0) and is discarded: receive-done and the holding register are unchanged. Writing register 4 clears the flag.
- R9: With multiprocessor enable (control bit 5) set in nine-bit mode, a frame is stored only if its ninth bit is 1 and it matches the station address (register 2) at every bit position set in the mask (register 3). Positions where the mask is 0 are ignored.
- R10: With multiprocessor enable clear, every frame with a valid stop bit is stored, whatever its ninth bit.
- R11: Hardware never clears the done flags. A control write sets each flag to the written value. `irq` is high whenever either flag is set.
- R12: A low pulse on `rxd` shorter than half a bit is rejected at the mid-start-bit check and stores nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle strobe at OSR times the bit rate |
| reg_sel | input | 3 | Register select: 0 control, 1 data, 2 station address, 3 mask, 4 error |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a read of register 1 empties the holding register) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register, combinational |
| irq | output | 1 | OR of the two done flags |
| txd | output | 1 | Serial output, idle high |
| rxd | input | 1 | Serial input, asynchronous |

## Verification
The assertions assume that `baud_tick` is a single-cycle strobe. They also assume that a read or write strobe names one register and lasts one cycle. Because the flag properties excuse only cycles that contain a control write, any other way of altering the control register would break them. The bench meets these assumptions in three ways. It generates the tick every second clock. It drives register strobes for exactly one cycle from its access tasks. It holds each serial bit on `rxd` for a whole bit time, changing it only on falling clock edges.

// File: rtl/mpsp_pkg.sv
package mpsp_pkg;
   typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_t;

   localparam logic [2:0] SEL_CTRL = 3'd0;
   localparam logic [2:0] SEL_DATA = 3'd1;
   localparam logic [2:0] SEL_ADDR = 3'd2;
   localparam logic [2:0] SEL_MASK = 3'd3;
   localparam logic [2:0] SEL_ERR  = 3'd4;

   localparam int B_RXDONE = 0;
   localparam int B_TXDONE = 1;
   localparam int B_RB8    = 2;
   localparam int B_TB8    = 3;
   localparam int B_RXEN   = 4;
   localparam int B_MPEN   = 5;
   localparam int B_NINE   = 6;
   localparam int B_OVR    = 7;
endpackage

// File: rtl/mpsp_tx.sv
module mpsp_tx #(
   parameter int OSR = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       go,
   input  logic [7:0] din,
   input  logic       ninth,
   input  logic       nine_mode,
   output logic       txd,
   output logic       busy,
   output logic       done
);
   localparam int CW = $clog2(OSR);
   localparam logic [CW-1:0] LAST_TICK = CW'(OSR - 1);

   logic [10:0]   shreg;
   logic [3:0]    left;
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg <= '1;
         left  <= '0;
         cnt   <= '0;
         busy  <= 1'b0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         if (!busy) begin
            if (go) begin
               shreg <= {1'b1, (nine_mode ? ninth : 1'b1), din, 1'b0};
               left  <= nine_mode ? 4'd11 : 4'd10;
               cnt   <= '0;
               busy  <= 1'b1;
            end
         end else if (tick) begin
            if (cnt == LAST_TICK) begin
               cnt   <= '0;
               shreg <= {1'b1, shreg[10:1]};
               left  <= left - 4'd1;
               if (left == 4'd1) begin
                  busy <= 1'b0;
                  done <= 1'b1;
               end
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

   assign txd = busy ? shreg[0] : 1'b1;

   // R2: the first bit on the line after a frame begins is the low start bit
   a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !txd);
endmodule

// File: rtl/mpsp_rx.sv
module mpsp_rx #(
   parameter int OSR  = 16,
   parameter int SYNC = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       rxd,
   input  logic       en,
   input  logic       nine_mode,
   output logic       fire,
   output logic [8:0] frame,
   output logic       stop_ok
);
   import mpsp_pkg::*;

   localparam int CW = $clog2(OSR);
   localparam logic [CW-1:0] HALF_TICK = CW'(OSR / 2 - 1);
   localparam logic [CW-1:0] LAST_TICK = CW'(OSR - 1);

   logic [SYNC-1:0] sy;
   logic            line;

   generate
      if (SYNC == 1) begin : g_sync1
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) sy <= '1;
            else        sy <= rxd;
      end else begin : g_syncn
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) sy <= '1;
            else        sy <= {sy[SYNC-2:0], rxd};
      end
   endgenerate

   assign line = sy[SYNC-1];

   rx_state_t     st;
   logic [CW-1:0] cnt;
   logic [3:0]    idx;
   logic [8:0]    sh;
   logic          armed;
   logic [3:0]    last_idx;

   assign last_idx = nine_mode ? 4'd8 : 4'd7;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= RX_IDLE;
         cnt     <= '0;
         idx     <= '0;
         sh      <= '0;
         armed   <= 1'b0;
         fire    <= 1'b0;
         frame   <= '0;
         stop_ok <= 1'b0;
      end else begin
         fire <= 1'b0;
         unique case (st)
            RX_IDLE: begin
               if (line) armed <= 1'b1;
               if (tick && en && armed && !line) begin
                  st    <= RX_START;
                  cnt   <= '0;
                  armed <= 1'b0;
               end
            end
            RX_START: if (tick) begin
               if (cnt == HALF_TICK) begin
                  cnt <= '0;
                  idx <= '0;
                  st  <= line ? RX_IDLE : RX_DATA;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            RX_DATA: if (tick) begin
               if (cnt == LAST_TICK) begin
                  cnt <= '0;
                  sh  <= {line, sh[8:1]};
                  if (idx == last_idx) st <= RX_STOP;
                  else                 idx <= idx + 4'd1;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            RX_STOP: if (tick) begin
               if (cnt == LAST_TICK) begin
                  fire    <= 1'b1;
                  stop_ok <= line;
                  frame   <= nine_mode ? sh : {1'b0, sh[8:1]};
                  st      <= RX_IDLE;
                  cnt     <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: st <= RX_IDLE;
         endcase
      end
   end

   // R5: with reception disabled an idle receiver never starts a frame
   a_r5_stay_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      (st == RX_IDLE && !en) |=> st == RX_IDLE);
endmodule

// File: rtl/mpsp_match.sv
module mpsp_match #(
   parameter int W = 8
) (
   input  logic [W-1:0] data,
   input  logic [W-1:0] addr,
   input  logic [W-1:0] mask,
   output logic         hit
);
   logic [W-1:0] ok;

   generate
      for (genvar i = 0; i < W; i++) begin : g_bit
         assign ok[i] = !mask[i] || (data[i] == addr[i]);
      end
   endgenerate

   assign hit = &ok;
endmodule

// File: rtl/mpsp_uart.sv
module mpsp_uart #(
   parameter int OSR  = 16,
   parameter int SYNC = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       baud_tick,
   input  logic [2:0] reg_sel,
   input  logic       reg_wr,
   input  logic       reg_rd,
   input  logic [7:0] reg_wdata,
   output logic [7:0] reg_rdata,
   output logic       irq,
   output logic       txd,
   input  logic       rxd
);
   import mpsp_pkg::*;

   initial begin : param_check
      assert (OSR >= 4 && (OSR % 2) == 0 && (OSR & (OSR - 1)) == 0)
         else $fatal(1, "OSR must be an even power of two, at least 4");
      assert (SYNC >= 1 && SYNC <= 4)
         else $fatal(1, "SYNC must lie in 1..4");
   end

   logic rx_done_q, tx_done_q, rb8_q, tb8_q, rxen_q, mpen_q, nine_q, ovr_q;
   logic ferr_q, full_q;
   logic [7:0] hold_q, myaddr_q, mask_q;

   logic wr_ctrl, wr_data, wr_addr, wr_mask, wr_err, rd_data;
   assign wr_ctrl = reg_wr && reg_sel == SEL_CTRL;
   assign wr_data = reg_wr && reg_sel == SEL_DATA;
   assign wr_addr = reg_wr && reg_sel == SEL_ADDR;
   assign wr_mask = reg_wr && reg_sel == SEL_MASK;
   assign wr_err  = reg_wr && reg_sel == SEL_ERR;
   assign rd_data = reg_rd && reg_sel == SEL_DATA;

   logic tx_busy, tx_evt;
   mpsp_tx #(.OSR(OSR)) u_tx (
      .clk(clk), .rst_n(rst_n), .tick(baud_tick), .go(wr_data),
      .din(reg_wdata), .ninth(tb8_q), .nine_mode(nine_q),
      .txd(txd), .busy(tx_busy), .done(tx_evt));

   logic       rx_fire, rx_stop_ok;
   logic [8:0] rx_frame;
   mpsp_rx #(.OSR(OSR), .SYNC(SYNC)) u_rx (
      .clk(clk), .rst_n(rst_n), .tick(baud_tick), .rxd(rxd), .en(rxen_q),
      .nine_mode(nine_q), .fire(rx_fire), .frame(rx_frame), .stop_ok(rx_stop_ok));

   logic hit;
   mpsp_match #(.W(8)) u_match (
      .data(rx_frame[7:0]), .addr(myaddr_q), .mask(mask_q), .hit(hit));

   logic accept, latch;
   assign accept = !(nine_q && mpen_q) || (rx_frame[8] && hit);
   assign latch  = rx_fire && rx_stop_ok && accept;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_done_q <= 1'b0; tx_done_q <= 1'b0; rb8_q <= 1'b0; tb8_q <= 1'b0;
         rxen_q    <= 1'b0; mpen_q    <= 1'b0; nine_q <= 1'b0; ovr_q <= 1'b0;
         ferr_q    <= 1'b0; full_q    <= 1'b0;
         hold_q    <= '0;   myaddr_q  <= '0;   mask_q <= '0;
      end else begin
         if (wr_ctrl) begin
            rx_done_q <= reg_wdata[B_RXDONE];
            tx_done_q <= reg_wdata[B_TXDONE];
            rb8_q     <= reg_wdata[B_RB8];
            tb8_q     <= reg_wdata[B_TB8];
            rxen_q    <= reg_wdata[B_RXEN];
            mpen_q    <= reg_wdata[B_MPEN];
            nine_q    <= reg_wdata[B_NINE];
            ovr_q     <= reg_wdata[B_OVR];
         end
         if (wr_addr) myaddr_q <= reg_wdata;
         if (wr_mask) mask_q   <= reg_wdata;
         if (wr_err)  ferr_q   <= reg_wdata[0];
         if (tx_evt)  tx_done_q <= 1'b1;
         if (rx_fire && !rx_stop_ok) ferr_q <= 1'b1;
         if (rd_data) full_q <= 1'b0;
         if (latch) begin
            hold_q    <= rx_frame[7:0];
            full_q    <= 1'b1;
            rx_done_q <= 1'b1;
            if (nine_q) rb8_q <= rx_frame[8];
            if (full_q && !rd_data) ovr_q <= 1'b1;
         end
      end
   end

   always_comb begin
      unique case (reg_sel)
         SEL_CTRL: reg_rdata = {ovr_q, nine_q, mpen_q, rxen_q, tb8_q, rb8_q, tx_done_q, rx_done_q};
         SEL_DATA: reg_rdata = hold_q;
         SEL_ADDR: reg_rdata = myaddr_q;
         SEL_MASK: reg_rdata = mask_q;
         SEL_ERR:  reg_rdata = {7'd0, ferr_q};
         default:  reg_rdata = 8'd0;
      endcase
   end

   assign irq = rx_done_q | tx_done_q;

   // R11: done flags only fall through a control write
   a_r11_rx_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_done_q && !wr_ctrl) |=> rx_done_q);
   a_r11_tx_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_done_q && !wr_ctrl) |=> tx_done_q);
   // R7: overrun holds until a control write
   a_r7_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_q && !wr_ctrl) |=> ovr_q);
   // R6: overrun cannot appear unless a byte lands on a full holding register
   a_r6_ovr_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
      (!ovr_q && !wr_ctrl && !(latch && full_q)) |=> !ovr_q);
   // R3: transmit completion comes only from a frame in flight
   a_r3_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
      tx_evt |-> $past(tx_busy));
   // R9: in multiprocessor nine-bit mode an accepted frame carried a set ninth bit
   a_r9_mp_ninth_set: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(rx_done_q) && !$past(wr_ctrl) && nine_q && mpen_q) |-> rb8_q);
endmodule

// File: tb/sim_mpsp_uart.sv
module sim_mpsp_uart;
   localparam int OSR  = 16;
   localparam int BITC = OSR * 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       baud_tick = 1'b0;
   logic [2:0] reg_sel = 3'd0;
   logic       reg_wr = 1'b0;
   logic       reg_rd = 1'b0;
   logic [7:0] reg_wdata = 8'd0;
   logic [7:0] reg_rdata;
   logic       irq, txd;
   logic       rxd = 1'b1;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   mpsp_uart #(.OSR(OSR), .SYNC(2)) u0 (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .reg_sel(reg_sel),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq(irq), .txd(txd), .rxd(rxd));

   always #5 clk = ~clk;

   initial forever begin
      @(negedge clk);
      baud_tick = ~baud_tick;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_sel = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_sel = a; reg_rd = 1'b1;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   // bits of a frame in line order; pre = negedges already spent since the write edge
   task automatic chk_tx(input logic [10:0] fr, input int n, input int pre, input string req);
      int bad = 0;
      repeat (16 - pre) @(negedge clk);
      for (int k = 0; k < n; k++) begin
         if (txd !== fr[k]) bad++;
         repeat (BITC) @(negedge clk);
      end
      chk(bad == 0, req, bad, 0);
   endtask

   task automatic send_rx(input logic [8:0] v, input bit nine, input bit stopv);
      @(negedge clk);
      rxd = 1'b0;
      repeat (BITC) @(negedge clk);
      for (int i = 0; i < (nine ? 9 : 8); i++) begin
         rxd = v[i];
         repeat (BITC) @(negedge clk);
      end
      rxd = stopv;
      repeat (BITC) @(negedge clk);
      rxd = 1'b1;
      repeat (BITC) @(negedge clk);
   endtask

   // control image: flags cleared, configuration kept
   function automatic logic [7:0] cfg(input bit nine, input bit mp, input bit en, input bit tb8);
      return {1'b0, nine, mp, en, tb8, 3'b000};
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [7:0] r, c, prev;
      logic [7:0] txv [6];
      logic [7:0] mk [3];
      logic [7:0] probe [8];
      txv = '{8'h00, 8'hFF, 8'hA5, 8'h3C, 8'h81, 8'h5E};
      mk = '{8'hFF, 8'hF0, 8'h00};
      probe = '{8'h5A, 8'h5B, 8'h4A, 8'h55, 8'hA5, 8'h50, 8'h00, 8'hDA};

      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1 reset state
      for (int a = 0; a < 5; a++) begin
         rd(3'(a), r);
         chk(r == 8'h00, "R1 register reset", r, 0);
      end
      chk(txd === 1'b1, "R1 txd idle", txd, 1);
      chk(irq === 1'b0, "R1 irq low", irq, 0);

      // R2/R3 eight-bit transmit sweep
      wr(3'd0, cfg(0, 0, 0, 0));
      for (int i = 0; i < 6; i++) begin
         wr(3'd1, txv[i]);
         chk_tx({1'b1, 1'b1, txv[i], 1'b0}, 10, 0, "R2 tx 8-bit frame");
         rd(3'd0, r);
         chk(r[1] == 1'b1, "R3 tx done set", r, 2);
         chk(irq === 1'b1, "R11 irq from tx done", irq, 1);
         wr(3'd0, cfg(0, 0, 0, 0));
         chk(irq === 1'b0, "R11 irq clears with flag", irq, 0);
      end

      // R2 nine-bit transmit, both TB8 values
      for (int t = 0; t < 2; t++) begin
         wr(3'd0, cfg(1, 0, 0, t[0]));
         wr(3'd1, 8'h6C);
         chk_tx({1'b1, t[0], 8'h6C, 1'b0}, 11, 0, "R2 tx 9-bit frame");
      end

      // R3 write during a busy frame is ignored
      wr(3'd0, cfg(0, 0, 0, 0));
      wr(3'd1, 8'hC3);
      wr(3'd1, 8'h18);
      chk_tx({1'b1, 1'b1, 8'hC3, 1'b0}, 10, 2, "R3 busy write ignored");
      repeat (BITC * 2) @(negedge clk);
      chk(txd === 1'b1, "R3 no second frame", txd, 1);
      wr(3'd0, cfg(0, 0, 1, 0));

      // R4 eight-bit receive sweep
      for (int d = 0; d < 256; d += 7) begin
         send_rx({1'b0, 8'(d)}, 0, 1);
         rd(3'd0, c);
         chk(c[0] == 1'b1, "R4 rx done set", c, 1);
         rd(3'd1, r);
         chk(r == 8'(d), "R4 rx data", r, d);
         wr(3'd0, cfg(0, 0, 1, 0));
      end
      prev = 8'(252);

      // R5 receive disabled
      wr(3'd0, cfg(0, 0, 0, 0));
      send_rx({1'b0, 8'h77}, 0, 1);
      rd(3'd0, c);
      chk(c[0] == 1'b0, "R5 no rx done when disabled", c, 0);
      rd(3'd1, r);
      chk(r == prev, "R5 holding unchanged", r, prev);

      // R6/R7 overrun
      wr(3'd0, cfg(0, 0, 1, 0));
      send_rx({1'b0, 8'h11}, 0, 1);
      send_rx({1'b0, 8'h22}, 0, 1);
      rd(3'd0, c);
      chk(c[7] == 1'b1, "R6 overrun set", c, 8'h80);
      rd(3'd1, r);
      chk(r == 8'h22, "R6 newest byte kept", r, 8'h22);
      send_rx({1'b0, 8'h33}, 0, 1);
      rd(3'd0, c);
      chk(c[7] == 1'b1, "R7 overrun held after read", c, 8'h80);
      wr(3'd0, cfg(0, 0, 1, 0));
      rd(3'd0, c);
      chk(c[7] == 1'b0, "R7 overrun cleared by write", c, 0);
      rd(3'd1, r);
      send_rx({1'b0, 8'h44}, 0, 1);
      rd(3'd0, c);
      chk(c[7] == 1'b0, "R6 no overrun after read", c, 0);
      rd(3'd1, r);
      prev = r;
      wr(3'd0, cfg(0, 0, 1, 0));

      // R8 framing error
      send_rx({1'b0, 8'h99}, 0, 0);
      rd(3'd4, r);
      chk(r == 8'h01, "R8 framing error set", r, 1);
      rd(3'd0, c);
      chk(c[0] == 1'b0, "R8 no rx done", c, 0);
      rd(3'd1, r);
      chk(r == prev, "R8 holding unchanged", r, prev);
      wr(3'd4, 8'h00);
      rd(3'd4, r);
      chk(r == 8'h00, "R8 framing error cleared", r, 0);

      // R9 masked address sweep in multiprocessor mode
      wr(3'd2, 8'h5A);
      for (int m = 0; m < 3; m++) begin
         wr(3'd3, mk[m]);
         for (int p = 0; p < 8; p++) begin
            for (int b = 0; b < 2; b++) begin
               bit exp;
               wr(3'd0, cfg(1, 1, 1, 0));
               rd(3'd1, prev);
               exp = (b == 1) && (((probe[p] ^ 8'h5A) & mk[m]) == 8'h00);
               send_rx({b[0], probe[p]}, 1, 1);
               rd(3'd0, c);
               chk(c[0] == exp, "R9 address filter", c[0], exp);
               rd(3'd1, r);
               chk(r == (exp ? probe[p] : prev), "R9 stored byte", r, exp ? probe[p] : prev);
               if (exp) chk(c[2] == 1'b1, "R4 rb8 from ninth bit", c, 4);
            end
         end
      end

      // R10 multiprocessor off, nine-bit: everything accepted
      for (int b = 0; b < 2; b++) begin
         wr(3'd0, cfg(1, 0, 1, 0) | {5'd0, ~b[0], 2'd0});
         send_rx({b[0], 8'hE7}, 1, 1);
         rd(3'd0, c);
         chk(c[0] == 1'b1 && c[2] == b[0], "R10 accepted with rb8", c, {b[0], 2'b01});
         rd(3'd1, r);
         chk(r == 8'hE7, "R10 data", r, 8'hE7);
      end

      // R11 flags independent and sticky
      wr(3'd0, cfg(0, 0, 1, 0));
      wr(3'd1, 8'h0F);
      repeat (BITC * 11) @(negedge clk);
      send_rx({1'b0, 8'hF0}, 0, 1);
      repeat (BITC * 4) @(negedge clk);
      rd(3'd0, c);
      chk(c[1:0] == 2'b11, "R11 both flags held", c[1:0], 3);
      wr(3'd0, cfg(0, 0, 1, 0) | 8'h02);
      chk(irq === 1'b1, "R11 irq from tx flag alone", irq, 1);
      rd(3'd0, c);
      chk(c[1:0] == 2'b10, "R11 rx cleared, tx kept", c[1:0], 2);
      wr(3'd0, cfg(0, 0, 1, 0));
      rd(3'd1, prev);

      // R12 short glitch
      @(negedge clk);
      rxd = 1'b0;
      repeat (OSR / 2) @(negedge clk);
      rxd = 1'b1;
      repeat (BITC * 12) @(negedge clk);
      rd(3'd0, c);
      chk(c[0] == 1'b0, "R12 glitch rejected", c, 0);
      rd(3'd4, r);
      chk(r == 8'h00, "R12 no framing error", r, 0);

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule